// File: doc/BRIEF.md
# Backup Power Switchover Controller

This block decides which source feeds a protected rail, such as the supply of a battery-backed static RAM. It chooses between the main supply and a backup source such as a battery or a large capacitor. It also produces an active-low power-fail warning. Its inputs are four single-bit comparator results that are already synchronous to the clock:
- main supply above the reset threshold
- main supply above the lower switchover threshold
- backup voltage above the main supply
- an external monitored voltage above its reference

The analog switches and comparators sit outside the block.

The rail moves to backup only when both of these hold: the main supply is below the switchover threshold, and the backup voltage is higher than the main supply. The rail moves back to the main supply only when the main supply clears the higher reset threshold. This gap between the two thresholds gives built-in hysteresis. On the return, the block emits a one-cycle start pulse to the reset sequencer's timer, so the rail is back on main one full reset timeout before reset is released.

Each comparator flag passes through a deglitcher before it can act. The rail select also has a one-cycle dwell, so it cannot chatter.

Top module: `supsw_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rail_sel_backup_o` is 1 (backup), `pwr_fail_n_o` is 0 and `rst_timer_start_o` is 0.
- R2: The rail changes from main to backup only when, after filtering, the switchover flag is 0 and the backup-above-main flag is 1.
- R3: While the filtered switchover flag is 1, any value or toggling of the backup-above-main flag leaves the rail on main and produces no timer start pulse.
- R4: From backup, the rail returns to main only when the filtered reset-threshold flag is 1. A switchover flag of 1 alone keeps the rail on backup.
- R5: `rst_timer_start_o` is a one-cycle pulse. It is high exactly in the cycle where `rail_sel_backup_o` first reads 0 after a backup period, and at no other time.
- R6: `pwr_fail_n_o` is 0 whenever the filtered power-fail flag is 0 or the filtered switchover flag is 0. Otherwise it is 1.
- R7: A raw flag takes effect only after it has differed from its filtered value for `STABLE_CYC` consecutive clock edges; a shorter excursion is ignored. An input applied before edge 1 is reflected on the outputs after edge `STABLE_CYC`+1, and not after edge `STABLE_CYC`.
- R8: `rail_sel_backup_o` never changes in two consecutive cycles. A transition that is still requested in the cycle after a change takes effect one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_above_rst_i | input | 1 | Main supply above reset threshold |
| cmp_above_sw_i | input | 1 | Main supply above switchover threshold |
| cmp_bkp_gt_main_i | input | 1 | Backup voltage above main supply |
| cmp_pfi_ok_i | input | 1 | External monitored input above its reference |
| rail_sel_backup_o | output | 1 | 1 = rail fed from backup, 0 = from main |
| pwr_fail_n_o | output | 1 | Power-fail warning, low when failing |
| rst_timer_start_o | output | 1 | One-cycle start pulse to the reset timer |

## Verification
Two events can fall on the same clock edge. The first is the return of the rail to main, together with its timer start pulse. The second is the rise of the power-fail output.

The bench provokes this by raising the reset-threshold and switchover flags together while the rail is on backup. It first checks that neither output has moved after `STABLE_CYC` edges. It then checks that the rail, the power-fail output and the pulse all change on the very next edge, and that the pulse is gone one cycle later.

A second overlap is a return request and a leave request in adjacent cycles. That is forced with a flag combination that asks for both, and it is judged by counting rail changes and confirming that no two are adjacent.

// File: rtl/supsw_pkg.sv
package supsw_pkg;

    localparam int unsigned NUM_FLAGS = 4;

    // Bit order is fixed: the top packs raw inputs into this vector.
    typedef struct packed {
        logic above_rst;   // bit 3
        logic above_sw;    // bit 2
        logic bkp_high;    // bit 1
        logic pfi_ok;      // bit 0
    } flags_t;

    typedef enum logic {
        RAIL_BACKUP = 1'b0,
        RAIL_MAIN   = 1'b1
    } rail_e;

    function automatic logic want_backup(flags_t f);
        return (!f.above_sw) && f.bkp_high;
    endfunction

    function automatic logic want_main(flags_t f);
        return f.above_rst;
    endfunction

    function automatic logic power_good(flags_t f);
        return f.above_sw && f.pfi_ok;
    endfunction

endpackage

// File: rtl/supsw_deglitch.sv
module supsw_deglitch #(
    parameter int unsigned STABLE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic filt_o
);
    localparam int unsigned CW = (STABLE_CYC < 2) ? 1 : $clog2(STABLE_CYC);
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYC - 1);

    logic [CW-1:0] run_q;
    logic          filt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            filt_q <= 1'b0;
        end else if (raw_i == filt_q) begin
            run_q <= '0;
        end else if (run_q == LAST) begin
            run_q  <= '0;
            filt_q <= raw_i;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign filt_o = filt_q;

    AST_FILT_FOLLOWS_RAW: assert property (@(posedge clk) disable iff (rst)
        (filt_q != $past(filt_q)) |-> ($past(raw_i) == filt_q)); // R7

endmodule

// File: rtl/supsw_rail_fsm.sv
module supsw_rail_fsm
    import supsw_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  flags_t flt_i,
    output rail_e  rail_o,
    output logic   tmr_start_o
);
    rail_e rail_q;
    logic  dwell_q;
    logic  start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rail_q  <= RAIL_BACKUP;
            dwell_q <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            dwell_q <= 1'b0;
            if (!dwell_q) begin
                case (rail_q)
                    RAIL_BACKUP: if (want_main(flt_i)) begin
                        rail_q  <= RAIL_MAIN;
                        dwell_q <= 1'b1;
                        start_q <= 1'b1;
                    end
                    RAIL_MAIN: if (want_backup(flt_i)) begin
                        rail_q  <= RAIL_BACKUP;
                        dwell_q <= 1'b1;
                    end
                    default: rail_q <= RAIL_BACKUP;
                endcase
            end
        end
    end

    assign rail_o      = rail_q;
    assign tmr_start_o = start_q;

    AST_LEAVE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
        (rail_q == RAIL_BACKUP && $past(rail_q) == RAIL_MAIN)
            |-> (!$past(flt_i.above_sw) && $past(flt_i.bkp_high))); // R2

    AST_HOLD_ABOVE_SW: assert property (@(posedge clk) disable iff (rst)
        (rail_q == RAIL_MAIN && flt_i.above_sw) |=> (rail_q == RAIL_MAIN)); // R3

    AST_RETURN_NEEDS_RST: assert property (@(posedge clk) disable iff (rst)
        (rail_q == RAIL_MAIN && $past(rail_q) == RAIL_BACKUP)
            |-> $past(flt_i.above_rst)); // R4

    AST_PULSE_ON_RETURN: assert property (@(posedge clk) disable iff (rst)
        start_q |-> (rail_q == RAIL_MAIN && $past(rail_q) == RAIL_BACKUP)); // R5

    AST_SELECT_DWELL: assert property (@(posedge clk) disable iff (rst)
        (rail_q != $past(rail_q)) |=> $stable(rail_q)); // R8

endmodule

// File: rtl/supsw_pfail.sv
module supsw_pfail
    import supsw_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  flags_t flt_i,
    output logic   pf_n_o
);
    logic pf_q;

    always_ff @(posedge clk) begin
        if (rst) pf_q <= 1'b0;
        else     pf_q <= power_good(flt_i);
    end

    assign pf_n_o = pf_q;

    AST_PF_LOW: assert property (@(posedge clk) disable iff (rst)
        (!flt_i.above_sw || !flt_i.pfi_ok) |=> !pf_q); // R6

    AST_PF_HIGH: assert property (@(posedge clk) disable iff (rst)
        (flt_i.above_sw && flt_i.pfi_ok) |=> pf_q); // R6

endmodule

// File: rtl/supsw_ctrl.sv
module supsw_ctrl
    import supsw_pkg::*;
#(
    parameter int unsigned STABLE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic cmp_above_rst_i,
    input  logic cmp_above_sw_i,
    input  logic cmp_bkp_gt_main_i,
    input  logic cmp_pfi_ok_i,
    output logic rail_sel_backup_o,
    output logic pwr_fail_n_o,
    output logic rst_timer_start_o
);
    logic [NUM_FLAGS-1:0] raw_v;
    logic [NUM_FLAGS-1:0] flt_v;
    flags_t               flt_s;
    rail_e                rail;

    assign raw_v = {cmp_above_rst_i, cmp_above_sw_i, cmp_bkp_gt_main_i, cmp_pfi_ok_i};

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flt
        supsw_deglitch #(.STABLE_CYC(STABLE_CYC)) u_dg (
            .clk    (clk),
            .rst    (rst),
            .raw_i  (raw_v[g]),
            .filt_o (flt_v[g])
        );
    end

    assign flt_s = flags_t'(flt_v);

    supsw_rail_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .flt_i       (flt_s),
        .rail_o      (rail),
        .tmr_start_o (rst_timer_start_o)
    );

    supsw_pfail u_pf (
        .clk    (clk),
        .rst    (rst),
        .flt_i  (flt_s),
        .pf_n_o (pwr_fail_n_o)
    );

    assign rail_sel_backup_o = (rail == RAIL_BACKUP);

    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (rail_sel_backup_o && !pwr_fail_n_o && !rst_timer_start_o)); // R1

endmodule

// File: tb/supsw_ctrl_bench.sv
module supsw_ctrl_bench;
    localparam int unsigned N = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_rst = 0, a_sw = 0, a_bk = 0, a_pf = 0;
    logic sel_bkp, pf_n, tstart;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    supsw_ctrl #(.STABLE_CYC(N)) u_supsw_ctrl (
        .clk               (clk),
        .rst               (rst),
        .cmp_above_rst_i   (a_rst),
        .cmp_above_sw_i    (a_sw),
        .cmp_bkp_gt_main_i (a_bk),
        .cmp_pfi_ok_i      (a_pf),
        .rail_sel_backup_o (sel_bkp),
        .pwr_fail_n_o      (pf_n),
        .rst_timer_start_o (tstart)
    );

    always @(negedge clk) if (!rst && tstart) pulses++;

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_int(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(logic r, logic s, logic b, logic p);
        a_rst = r; a_sw = s; a_bk = b; a_pf = p;
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_main();
        drive(1, 1, 0, 1); cyc(N + 3);
    endtask

    task automatic go_backup();
        go_main();
        drive(0, 0, 1, 1); cyc(N + 3);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        cyc(3);
        // R1: reset values
        chk("R1 rail during reset", sel_bkp, 1'b1);
        chk("R1 pf during reset", pf_n, 1'b0);
        chk("R1 pulse during reset", tstart, 1'b0);
        rst = 1'b0;
        cyc(1);
        chk("R1 rail after reset", sel_bkp, 1'b1);
        chk("R1 pf after reset", pf_n, 1'b0);

        // R7 latency + same-cycle return and pf rise (R5, R6)
        drive(0, 0, 1, 1); cyc(N + 3);
        pulses = 0;
        drive(1, 1, 0, 1);
        cyc(N);
        chk("R7 rail not yet moved", sel_bkp, 1'b1);
        chk("R7 pf not yet moved", pf_n, 1'b0);
        cyc(1);
        chk("R4 rail returned", sel_bkp, 1'b0);
        chk("R6 pf rose same cycle", pf_n, 1'b1);
        chk("R5 pulse with return", tstart, 1'b1);
        cyc(1);
        chk("R5 pulse one cycle", tstart, 1'b0);
        chk_int("R5 pulse count", pulses, 1);

        // Sweep: every flag combination from both steady states (R2 R3 R4 R5 R6)
        for (int st = 0; st < 2; st++) begin
            for (int c = 0; c < 16; c++) begin
                logic r, s, b, p, exp_bkp, osc;
                int   exp_p;
                r = c[3]; s = c[2]; b = c[1]; p = c[0];
                if (st == 0) go_main(); else go_backup();
                pulses = 0;
                drive(r, s, b, p);
                cyc(N + 3);
                osc = 1'b0;
                exp_p = 0;
                if (st == 0) begin
                    exp_bkp = (!s && b);
                    if (exp_bkp && r) osc = 1'b1;
                end else begin
                    exp_bkp = !r;
                    exp_p = r ? 1 : 0;
                    if (r && !s && b) osc = 1'b1;
                end
                chk("R6 sweep pf", pf_n, s && p);
                if (!osc) begin
                    chk(st == 0 ? "R2 R3 sweep rail from main" : "R4 sweep rail from backup",
                        sel_bkp, exp_bkp);
                    chk_int("R5 sweep pulse count", pulses, exp_p);
                end
            end
        end

        // R4: switchover flag alone keeps backup
        go_backup();
        drive(0, 1, 0, 1); cyc(N + 3);
        chk("R4 sw alone stays backup", sel_bkp, 1'b1);
        chk("R6 pf high with sw and pfi", pf_n, 1'b1);

        // R7: glitch shorter than STABLE_CYC ignored
        go_main();
        begin
            int bad = 0;
            drive(1, 0, 1, 0); cyc(N - 1);
            drive(1, 1, 0, 1);
            for (int k = 0; k < N + 3; k++) begin
                cyc(1);
                if (sel_bkp !== 1'b0 || pf_n !== 1'b1) bad++;
            end
            chk_int("R7 short glitch ignored", bad, 0);
        end

        // R3: backup flag toggling / removal above switchover threshold
        go_main();
        pulses = 0;
        begin
            int bad = 0;
            for (int k = 0; k < 12; k++) begin
                drive(1, 1, k[0], 1);
                cyc(1);
                if (sel_bkp !== 1'b0) bad++;
            end
            drive(1, 1, 1, 1); cyc(N + 3);
            if (sel_bkp !== 1'b0) bad++;
            drive(1, 1, 0, 1); cyc(N + 3);
            if (sel_bkp !== 1'b0) bad++;
            chk_int("R3 backup flag has no effect", bad, 0);
            chk_int("R3 no timer pulse", pulses, 0);
        end

        // R8: conflicting requests force alternation with dwell
        go_backup();
        pulses = 0;
        drive(1, 0, 1, 1);
        begin
            int changes = 0, adj = 0, rises = 0;
            logic prev, prev_ch;
            prev = sel_bkp; prev_ch = 1'b0;
            for (int k = 0; k < 24; k++) begin
                logic ch;
                cyc(1);
                ch = (sel_bkp !== prev);
                if (ch) changes++;
                if (ch && prev == 1'b1) rises++;
                if (ch && prev_ch) adj++;
                prev_ch = ch;
                prev = sel_bkp;
            end
            chk_int("R8 no adjacent changes", adj, 0);
            chk("R8 alternation occurred", changes >= 4, 1'b1);
            chk_int("R5 pulses match returns", pulses, rises);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule